// File: doc/BRIEF.md
# Multiple-register transfer sequencer

This block serialises one decoded block-transfer instruction into a run of single-word memory accesses. The condition field is removed upstream, so the block receives the lower 28 bits of the word. It also takes the current value of the base register and a start strobe. The block then visits every register named in the 16-bit mask, lowest index first. Each visit is one memory request. A store reads the register file and sends the word to memory. A load writes the returned word into the register file in the same cycle the memory signals ready.

The block computes the first address from the base for all four stepping modes: ascending or descending, with the offset applied before or after each access. After that, addresses always climb in 4-byte steps. The lowest-numbered register therefore always lands at the lowest address. On request, the block writes the final address back into the base register. A flag routes every register-file access of the transfer to the user bank. An empty mask is reported and no transfer is made. A one-cycle done pulse closes every operation.

Top module: `blk_xfer_seq`

## Requirements
- R1: Instruction field positions are fixed:
  - bit 24: offset before access (1) or after access (0);
  - bit 23: ascending (1) or descending (0);
  - bit 22: user bank;
  - bit 21: write-back;
  - bit 20: load (1) or store (0);
  - bits 19..16: base register index;
  - bits 15..0: register mask, where bit i selects register i;
  - bits 27..25: must hold 100.
- R2: Registers are transferred in ascending index order, one per completed handshake (mem_req_o and mem_ready_i both high). While mem_ready_i is low, the request, address and register index hold steady.
- R3: With N set bits in the mask, the access addresses are S, S+4, S+8 and so on. S depends on the mode:
  - ascending, offset after: S = base;
  - ascending, offset before: S = base+4;
  - descending, offset after: S = base-4N+4;
  - descending, offset before: S = base-4N.
- R4: A store drives mem_we_o high and mem_wdata_o equal to the selected register's value. It never writes the register file.
- R5: A load drives mem_we_o low. In the cycle the handshake completes, it writes mem_rdata_i into the selected register.
- R6: With write-back set and a non-empty mask, the cycle after the last handshake writes base+4N (ascending) or base-4N (descending) into the base register, in the current bank.
- R7: With write-back clear, the base register receives no extra write.
- R8: With the user-bank flag set, every register read and every load write of the transfer carries the user-bank select. The write-back itself always targets the current bank.
- R9: An all-zero mask issues no memory request and no register write. It raises bad_mask_o together with done_o.
- R10: done_o is high for exactly one cycle. It follows the last handshake, or the write-back cycle when there is one.
- R11: start_i is ignored while busy_o is high. Changes to instr_i and base_val_i during an operation do not affect it.
- R12: After reset the block is idle, with busy_o, mem_req_o, rf_we_o and done_o all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| instr_i | input | 28 | Decoded instruction, condition field removed |
| base_val_i | input | 32 | Current base register value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bad_mask_o | output | 1 | Empty mask, valid with done_o |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (store) |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Store data |
| mem_ready_i | input | 1 | Memory handshake complete |
| mem_rdata_i | input | 32 | Load data, valid with mem_ready_i |
| rf_rd_idx_o | output | 4 | Register-file read index |
| rf_rd_user_o | output | 1 | Read from the user bank |
| rf_rd_data_i | input | 32 | Register-file read data, combinational |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | 4 | Register-file write index |
| rf_wr_user_o | output | 1 | Write to the user bank |
| rf_wr_data_o | output | 32 | Register-file write data |

## Verification
A load's register write and the base write-back both use the single register-file write port. The hazard is sharpest when the base register is also in the mask. The bench provokes this with a load that has write-back set and the base register selected. It checks that the loaded word is written in the handshake cycle and that the write-back follows in its own later cycle, so the final base holds base±4N. Memory readiness is stretched at random so that the last handshake and the write-back cycle fall at varying distances from the start strobe.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_WB, ST_DONE} xfer_st_e;

  localparam int unsigned POS_PRE  = 24;
  localparam int unsigned POS_UP   = 23;
  localparam int unsigned POS_USR  = 22;
  localparam int unsigned POS_WB   = 21;
  localparam int unsigned POS_LD   = 20;
  localparam int unsigned POS_RN   = 16;
  localparam int unsigned POS_OPC  = 25;
  localparam logic [2:0]  OPC_BLK  = 3'b100;
endpackage

// File: rtl/blk_xfer_pick.sv
module blk_xfer_pick #(
  parameter int unsigned NREG = 16,
  localparam int unsigned IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [IW-1:0]   idx_o,
  output logic [NREG-1:0] rest_o,
  output logic            last_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign rest_o = mask_i & (mask_i - 1'b1);
  assign last_o = (rest_o == '0);
endmodule

// File: rtl/blk_xfer_addr.sv
module blk_xfer_addr #(
  parameter int unsigned NREG       = 16,
  parameter int unsigned AW         = 32,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned CW = $clog2(NREG) + 1
) (
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic            up_i,
  input  logic            pre_i,
  output logic [AW-1:0]   start_o,
  output logic [AW-1:0]   final_o
);
  logic [CW-1:0] cnt;
  logic [AW-1:0] span, step;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt = cnt + {{(CW-1){1'b0}}, mask_i[i]};
    end
  end

  assign step = AW'(WORD_BYTES);
  assign span = AW'(cnt) * step;

  always_comb begin
    unique case ({up_i, pre_i})
      2'b10:   start_o = base_i;
      2'b11:   start_o = base_i + step;
      2'b00:   start_o = base_i - span + step;
      default: start_o = base_i - span;
    endcase
    final_o = up_i ? base_i + span : base_i - span;
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int unsigned NREG       = 16,
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned IW = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [27:0]   instr_i,
  input  logic [AW-1:0] base_val_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          bad_mask_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [IW-1:0] rf_rd_idx_o,
  output logic          rf_rd_user_o,
  input  logic [DW-1:0] rf_rd_data_i,
  output logic          rf_we_o,
  output logic [IW-1:0] rf_wr_idx_o,
  output logic          rf_wr_user_o,
  output logic [DW-1:0] rf_wr_data_o
);
  xfer_st_e        st_q;
  logic [NREG-1:0] mask_q, rest;
  logic [AW-1:0]   addr_q, final_q, start_addr, final_addr;
  logic [IW-1:0]   rn_q, cur_idx;
  logic            load_q, wb_q, user_q, bad_q, cur_last;
  logic [NREG-1:0] new_mask;

  assign new_mask = instr_i[NREG-1:0];

  blk_xfer_addr #(.NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base_i (base_val_i),
    .mask_i (new_mask),
    .up_i   (instr_i[POS_UP]),
    .pre_i  (instr_i[POS_PRE]),
    .start_o(start_addr),
    .final_o(final_addr)
  );

  blk_xfer_pick #(.NREG(NREG)) u_pick (
    .mask_i(mask_q),
    .idx_o (cur_idx),
    .rest_o(rest),
    .last_o(cur_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      final_q <= '0;
      rn_q    <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      user_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mask_q  <= new_mask;
          addr_q  <= start_addr;
          final_q <= final_addr;
          rn_q    <= instr_i[POS_RN +: IW];
          load_q  <= instr_i[POS_LD];
          wb_q    <= instr_i[POS_WB];
          user_q  <= instr_i[POS_USR];
          bad_q   <= (new_mask == '0);
          st_q    <= (new_mask == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (mem_ready_i) begin
          mask_q <= rest;
          addr_q <= addr_q + AW'(WORD_BYTES);
          if (cur_last) st_q <= wb_q ? ST_WB : ST_DONE;
        end
        ST_WB:   st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);
  assign bad_mask_o   = done_o && bad_q;
  assign mem_req_o    = (st_q == ST_XFER);
  assign mem_we_o     = mem_req_o && !load_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = rf_rd_data_i;
  assign rf_rd_idx_o  = cur_idx;
  assign rf_rd_user_o = user_q;
  assign rf_we_o      = (mem_req_o && load_q && mem_ready_i) || (st_q == ST_WB);
  assign rf_wr_idx_o  = (st_q == ST_WB) ? rn_q : cur_idx;
  assign rf_wr_user_o = (st_q == ST_WB) ? 1'b0 : user_q;
  assign rf_wr_data_o = (st_q == ST_WB) ? DW'(final_q) : mem_rdata_i;

  AST_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |-> instr_i[POS_OPC +: 3] == OPC_BLK); // R1
  AST_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(rf_rd_idx_o))); // R2
  AST_IDX_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || rf_rd_idx_o > $past(rf_rd_idx_o))); // R2
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + AW'(WORD_BYTES))); // R3
  AST_STORE_NO_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && rf_we_o)); // R4
  AST_BAD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_mask_o |-> $past(!mem_req_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

// File: tb/blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [27:0] instr_i = '0;
  logic [31:0] base_val_i = '0;
  logic        busy_o, done_o, bad_mask_o, mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rd_data_i, rf_wr_data_o;
  logic        mem_ready_i = 1'b0;
  logic [3:0]  rf_rd_idx_o, rf_wr_idx_o;
  logic        rf_rd_user_o, rf_we_o, rf_wr_user_o;

  int vectors = 0;
  int errors  = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  function automatic logic [31:0] cur_reg(int i);
    return 32'h1000_0000 + 32'(i) * 32'h111;
  endfunction
  function automatic logic [31:0] usr_reg(int i);
    return 32'h2000_0000 + 32'(i) * 32'h101;
  endfunction
  function automatic logic [31:0] mem_word(logic [31:0] a);
    return a ^ 32'h5A00_00C3;
  endfunction

  assign rf_rd_data_i = rf_rd_user_o ? usr_reg(int'(rf_rd_idx_o)) : cur_reg(int'(rf_rd_idx_o));
  assign mem_rdata_i  = mem_word(mem_addr_o);

  blk_xfer_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .instr_i(instr_i),
    .base_val_i(base_val_i), .busy_o(busy_o), .done_o(done_o),
    .bad_mask_o(bad_mask_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_user_o(rf_rd_user_o),
    .rf_rd_data_i(rf_rd_data_i), .rf_we_o(rf_we_o), .rf_wr_idx_o(rf_wr_idx_o),
    .rf_wr_user_o(rf_wr_user_o), .rf_wr_data_o(rf_wr_data_o)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [27:0] mk(bit p, bit u, bit s, bit w, bit l, logic [3:0] rn, logic [15:0] m);
    return {3'b100, p, u, s, w, l, rn, m};
  endfunction

  task automatic run_op(logic [27:0] ins, logic [31:0] base, bit rnd, bit hold);
    logic [15:0] m = ins[15:0];
    bit p = ins[24], u = ins[23], s = ins[22], w = ins[21], l = ins[20];
    logic [3:0] rn = ins[19:16];
    int n = 0, k = 0, cyc = 0;
    bit wb_seen = 0;
    int exp_idx[$];
    logic [31:0] st, fin;
    for (int i = 0; i < 16; i++) if (m[i]) begin exp_idx.push_back(i); n++; end
    if (u) st = p ? base + 4 : base;
    else   st = p ? base - 32'(4 * n) : base - 32'(4 * n) + 4;
    fin = u ? base + 32'(4 * n) : base - 32'(4 * n);
    @(negedge clk);
    instr_i = ins; base_val_i = base; start_i = 1'b1; mem_ready_i = 1'b0;
    forever begin
      @(negedge clk);
      start_i = hold;
      if (hold) begin instr_i = ins ^ 28'h00F_FFFF; base_val_i = base + 32'h100; end
      seed = seed * 32'd1103515245 + 32'd12345;
      mem_ready_i = rnd ? seed[16] : 1'b1;
      #1;
      cyc++;
      if (mem_req_o) begin
        chk(k < n, "R2 extra request", 32'(k), 32'(n));
        if (k < n) begin
          chk(mem_addr_o == st + 32'(4 * k), "R3 address", mem_addr_o, st + 32'(4 * k));
          chk(rf_rd_idx_o == 4'(exp_idx[k]), "R2 register order", 32'(rf_rd_idx_o), 32'(exp_idx[k]));
          chk(rf_rd_user_o == s, "R8 read bank", 32'(rf_rd_user_o), 32'(s));
          chk(mem_we_o == !l, "R4 R5 write enable", 32'(mem_we_o), 32'(!l));
          if (!l) chk(mem_wdata_o == (s ? usr_reg(exp_idx[k]) : cur_reg(exp_idx[k])),
                      "R4 store data", mem_wdata_o, s ? usr_reg(exp_idx[k]) : cur_reg(exp_idx[k]));
          if (mem_ready_i) begin
            if (l) begin
              chk(rf_we_o, "R5 load write enable", 32'(rf_we_o), 32'd1);
              chk(rf_wr_idx_o == 4'(exp_idx[k]), "R5 load index", 32'(rf_wr_idx_o), 32'(exp_idx[k]));
              chk(rf_wr_data_o == mem_word(st + 32'(4 * k)), "R5 load data", rf_wr_data_o, mem_word(st + 32'(4 * k)));
              chk(rf_wr_user_o == s, "R8 write bank", 32'(rf_wr_user_o), 32'(s));
            end else chk(!rf_we_o, "R4 store writes rf", 32'(rf_we_o), 32'd0);
            k++;
          end else chk(!rf_we_o, "R5 write before ready", 32'(rf_we_o), 32'd0);
        end
      end else if (rf_we_o) begin
        chk(w && n != 0 && k == n && !wb_seen, "R6 R7 R9 unexpected base write", 32'(w), 32'd0);
        chk(rf_wr_idx_o == rn, "R6 write-back index", 32'(rf_wr_idx_o), 32'(rn));
        chk(rf_wr_data_o == fin, "R6 write-back value", rf_wr_data_o, fin);
        chk(rf_wr_user_o == 1'b0, "R8 write-back bank", 32'(rf_wr_user_o), 32'd0);
        wb_seen = 1;
      end
      if (done_o) begin
        start_i = 1'b0;
        chk(k == n, "R10 transfers before done", 32'(k), 32'(n));
        chk(wb_seen == (w && n != 0), "R6 R7 write-back seen", 32'(wb_seen), 32'(w && n != 0));
        chk(bad_mask_o == (n == 0), "R9 bad mask flag", 32'(bad_mask_o), 32'(n == 0));
        break;
      end
      if (cyc > 400) begin
        chk(1'b0, "R10 no done", 32'(cyc), 32'd0);
        break;
      end
    end
    @(negedge clk);
    mem_ready_i = 1'b0;
    #1;
    chk(!done_o, "R10 done pulse width", 32'(done_o), 32'd0);
    chk(!busy_o, "R10 idle after done", 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !mem_req_o && !rf_we_o && !done_o, "R12 reset state",
        {28'd0, busy_o, mem_req_o, rf_we_o, done_o}, 32'd0);
    rst_n = 1'b1;
    run_op(mk(0,1,0,0,0,4'd13,16'h8421), 32'h0000_1000, 0, 0); // R1 R3 R4 R7 ascending after
    run_op(mk(1,0,0,1,0,4'd13,16'h4006), 32'h0000_2000, 1, 0); // R3 R6 descending before
    run_op(mk(1,1,0,0,1,4'd2, 16'hFFFF), 32'h0000_4000, 1, 0); // R2 R5 full mask
    run_op(mk(0,0,0,1,1,4'd9, 16'h0001), 32'h0000_3000, 0, 0); // R3 R6 single, descending after
    run_op(mk(0,1,1,0,1,4'd0, 16'h6000), 32'h0000_5000, 1, 1); // R8 R11
    run_op(mk(1,1,0,1,0,4'd4, 16'h0000), 32'h0000_6000, 0, 0); // R9
    run_op(mk(0,1,0,1,1,4'd3, 16'h0018), 32'h0000_7000, 1, 0); // R5 R6 base in list
    run_op(mk(1,0,1,1,0,4'd14,16'h8001), 32'h0000_8000, 1, 1); // R8 R11 R3
    run_op(mk(0,0,0,0,0,4'd1, 16'h00F0), 32'h0000_9000, 1, 0); // R3 R7
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule